// File: doc/BRIEF.md
# Clock-Configuration Register Target on a Two-Wire Serial Bus

This block is a standard-mode I2C target that keeps six 8-bit configuration bytes for an on-chip clock generator. The rest of the chip reads them continuously from a parallel output bus. The serial lines are oversampled by a faster system clock. The block drives SDA only by pulling it low through an open-drain output enable.

Writes use a block protocol only. After the write address, the first two bytes are acknowledged and dropped. The bytes that follow fill the registers in ascending order, starting at register 0. Reads return a byte count first and then every register in order. The block has no register pointer, so every access begins at register 0. A controller may end a write with STOP after any whole byte. It may restart at any time with a repeated START.

Top module: `clkcfg_i2c_target`

## Requirements
- R1: After reset, register 0 is 0x00 and registers 1 to 5 are 0xFF. Register k appears on cfg_o[8k+7:8k], and sda_oe is 0.
- R2: The block acknowledges the address byte 0xD2 (write) and 0xD3 (read) by pulling SDA low in the ninth clock. It does not acknowledge any other address byte, and it leaves the registers unchanged until the next START.
- R3: In a write, the block acknowledges the first two bytes after the address and changes no register with them.
- R4: In a write, the third and following bytes go to registers 0, 1, 2, up to 5 in that order. Each of these bytes is acknowledged, and bytes are sent MSB first.
- R5: A STOP after any complete byte ends the write. Registers already written keep their new values and the other registers keep their old values.
- R6: Write bytes after the one that lands in register 5 are acknowledged but change no register.
- R7: In a read, the block sends the value 6 first and then registers 0 to 5, MSB first. It continues after each controller ACK.
- R8: A controller NACK after a read byte ends the transfer. The block then keeps SDA released until the next START.
- R9: A repeated START, arriving even partway through a byte, returns the block to address matching.
- R10: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| cfg_o | output | 48 | The six configuration bytes; register k is at bits 8k+7:8k |

## Verification
A table of write transactions drives full six-byte writes, partial writes ended by STOP after one or three bytes, and a write that stops right after the two discarded bytes. Each write is followed by a full readback. Together these separate a block that ignores STOP placement from one that shifts data into the wrong register or stores the dropped bytes. Further directed cases cover foreign addresses, overlong writes, repeated STARTs in the middle of a byte, and an early NACK during a read. Each of these separates correct release of SDA from a block that keeps driving or keeps counting.

// File: rtl/clkcfg_i2c_pkg.sv
package clkcfg_i2c_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_RACK
    } bus_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] scl_pipe_d, scl_pipe_q;
    logic [STAGES-1:0] sda_pipe_d, sda_pipe_q;
    logic              scl_prev_d, scl_prev_q;
    logic              sda_prev_d, sda_prev_q;

    always_comb begin
        scl_pipe_d = {scl_pipe_q[LAST-1:0], scl_i};
        sda_pipe_d = {sda_pipe_q[LAST-1:0], sda_i};
        scl_prev_d = scl_pipe_q[LAST];
        sda_prev_d = sda_pipe_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_s     = scl_pipe_q[LAST];
    assign sda_s     = sda_pipe_q[LAST];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

    // R9: START and STOP can never be seen in the same cycle
    p_start_stop_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_det && stop_det));

endmodule

// File: rtl/cfg_regbank.sv
module cfg_regbank #(
    parameter int unsigned           N_REGS   = 6,
    parameter logic [N_REGS*8-1:0]   DEFAULTS = {{(N_REGS-1){8'hFF}}, 8'h00},
    localparam int unsigned          SW       = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SW-1:0]         wr_sel,
    input  logic [7:0]            wr_data,
    output logic [N_REGS*8-1:0]   cfg_o
);

    logic [7:0] regs_d [N_REGS];
    logic [7:0] regs_q [N_REGS];

    always_comb begin
        for (int k = 0; k < N_REGS; k++) begin
            regs_d[k] = regs_q[k];
            if (wr_en && wr_sel == SW'(k)) begin
                regs_d[k] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < N_REGS; k++) begin
                regs_q[k] <= DEFAULTS[k*8 +: 8];
            end
        end else begin
            for (int k = 0; k < N_REGS; k++) begin
                regs_q[k] <= regs_d[k];
            end
        end
    end

    for (genvar g = 0; g < N_REGS; g++) begin : g_flat
        assign cfg_o[g*8 +: 8] = regs_q[g];
    end

    // R4: the protocol engine never selects a register that does not exist
    p_sel_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_sel) < N_REGS));

endmodule

// File: rtl/i2c_block_engine.sv
module i2c_block_engine
    import clkcfg_i2c_pkg::*;
#(
    parameter int unsigned N_REGS  = 6,
    parameter logic [7:0]  WR_ADDR = 8'hD2,
    localparam int unsigned SW     = (N_REGS > 1) ? $clog2(N_REGS) : 1,
    localparam int unsigned SKIP   = 2,
    localparam int unsigned IDX_MAX = SKIP + N_REGS,
    localparam int unsigned IW     = $clog2(IDX_MAX + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_s,
    input  logic                  sda_s,
    input  logic                  scl_rise,
    input  logic                  scl_fall,
    input  logic                  start_det,
    input  logic                  stop_det,
    input  logic [N_REGS*8-1:0]   cfg_i,
    output logic                  wr_en,
    output logic [SW-1:0]         wr_sel,
    output logic [7:0]            wr_data,
    output logic                  sda_oe
);

    localparam logic [7:0] RD_ADDR = WR_ADDR | 8'h01;

    typedef struct packed {
        bus_state_e    state;
        logic [3:0]    bitcnt;
        logic [7:0]    shreg;
        logic          is_read;
        logic [IW-1:0] idx;
        logic          oe;
        logic          nack;
    } eng_t;

    eng_t          eng_d, eng_q;
    logic [7:0]    tx_byte;
    logic [IW-1:0] idx_inc;

    // byte to send for the current read index: count first, then registers
    always_comb begin
        tx_byte = 8'hFF;
        if (eng_q.idx == '0) begin
            tx_byte = 8'(N_REGS);
        end
        for (int k = 0; k < N_REGS; k++) begin
            if (eng_q.idx == IW'(k + 1)) begin
                tx_byte = cfg_i[k*8 +: 8];
            end
        end
        idx_inc = (eng_q.idx == IW'(IDX_MAX)) ? eng_q.idx : IW'(eng_q.idx + 1'b1);
    end

    always_comb begin
        eng_d   = eng_q;
        wr_en   = 1'b0;
        wr_sel  = '0;
        wr_data = eng_q.shreg;
        if (start_det) begin
            eng_d.state   = ST_ADDR;
            eng_d.bitcnt  = '0;
            eng_d.shreg   = '0;
            eng_d.is_read = 1'b0;
            eng_d.idx     = '0;
            eng_d.oe      = 1'b0;
            eng_d.nack    = 1'b0;
        end else if (stop_det) begin
            eng_d.state = ST_IDLE;
            eng_d.oe    = 1'b0;
        end else begin
            case (eng_q.state)
                ST_ADDR, ST_RX: begin
                    if (scl_rise && eng_q.bitcnt != 4'd8) begin
                        eng_d.shreg  = {eng_q.shreg[6:0], sda_s};
                        eng_d.bitcnt = 4'(eng_q.bitcnt + 1'b1);
                    end else if (scl_fall && eng_q.bitcnt == 4'd8) begin
                        eng_d.bitcnt = '0;
                        if (eng_q.state == ST_ADDR) begin
                            if (eng_q.shreg == WR_ADDR) begin
                                eng_d.state   = ST_ACK;
                                eng_d.oe      = 1'b1;
                                eng_d.is_read = 1'b0;
                            end else if (eng_q.shreg == RD_ADDR) begin
                                eng_d.state   = ST_ACK;
                                eng_d.oe      = 1'b1;
                                eng_d.is_read = 1'b1;
                            end else begin
                                eng_d.state = ST_IDLE;
                            end
                        end else begin
                            eng_d.state = ST_ACK;
                            eng_d.oe    = 1'b1;
                            if (eng_q.idx >= IW'(SKIP) && eng_q.idx < IW'(IDX_MAX)) begin
                                wr_en  = 1'b1;
                                wr_sel = SW'(eng_q.idx - IW'(SKIP));
                            end
                            eng_d.idx = idx_inc;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        eng_d.bitcnt = '0;
                        if (eng_q.is_read) begin
                            eng_d.state = ST_TX;
                            eng_d.shreg = tx_byte;
                            eng_d.oe    = ~tx_byte[7];
                            eng_d.idx   = idx_inc;
                        end else begin
                            eng_d.state = ST_RX;
                            eng_d.oe    = 1'b0;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (eng_q.bitcnt == 4'd7) begin
                            eng_d.state = ST_RACK;
                            eng_d.oe    = 1'b0;
                            eng_d.nack  = 1'b0;
                        end else begin
                            eng_d.shreg  = {eng_q.shreg[6:0], 1'b0};
                            eng_d.oe     = ~eng_q.shreg[6];
                            eng_d.bitcnt = 4'(eng_q.bitcnt + 1'b1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        eng_d.nack = sda_s;
                    end else if (scl_fall) begin
                        if (eng_q.nack) begin
                            eng_d.state = ST_IDLE;
                        end else begin
                            eng_d.state  = ST_TX;
                            eng_d.shreg  = tx_byte;
                            eng_d.oe     = ~tx_byte[7];
                            eng_d.idx    = idx_inc;
                            eng_d.bitcnt = '0;
                        end
                    end
                end
                default: begin
                    eng_d.oe = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{state: ST_IDLE, bitcnt: '0, shreg: '0, is_read: 1'b0,
                       idx: '0, oe: 1'b0, nack: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe = eng_q.oe;

    // R10: the SDA drive holds still while SCL stays high
    p_oe_stable_scl_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe));

    // R9: a START always restarts address matching
    p_start_to_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (eng_q.state == ST_ADDR));

    // R5: a STOP idles the engine with SDA released
    p_stop_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (eng_q.state == ST_IDLE && !sda_oe));

    // R2: an idle engine never pulls SDA
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_IDLE) |-> !sda_oe);

    // R8: a controller NACK ends the read at the following SCL fall
    p_nack_ends_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.state == ST_RACK && eng_q.nack && scl_fall && !start_det && !stop_det)
        |=> (eng_q.state == ST_IDLE));

endmodule

// File: rtl/clkcfg_i2c_target.sv
module clkcfg_i2c_target #(
    parameter int unsigned          N_REGS      = 6,
    parameter logic [7:0]           WR_ADDR     = 8'hD2,
    parameter int unsigned          SYNC_STAGES = 2,
    parameter logic [N_REGS*8-1:0]  REG_DEFAULTS = {{(N_REGS-1){8'hFF}}, 8'h00},
    localparam int unsigned         SW          = (N_REGS > 1) ? $clog2(N_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [N_REGS*8-1:0]   cfg_o
);

    logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic          wr_en;
    logic [SW-1:0] wr_sel;
    logic [7:0]    wr_data;

    i2c_line_sync #(
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_block_engine #(
        .N_REGS  (N_REGS),
        .WR_ADDR (WR_ADDR)
    ) i_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .cfg_i     (cfg_o),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .sda_oe    (sda_oe)
    );

    cfg_regbank #(
        .N_REGS   (N_REGS),
        .DEFAULTS (REG_DEFAULTS)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .cfg_o   (cfg_o)
    );

endmodule

// File: tb/test_clkcfg_i2c_target.sv
`timescale 1ns/1ps
module test_clkcfg_i2c_target;

    localparam int Q = 10;
    localparam int NV = 5;
    // each entry: [55:48] number of register bytes, [47:0] bytes for registers 0..5 (first at top)
    localparam logic [55:0] WR_TAB [NV] = '{
        {8'd6, 48'h11_22_33_44_55_66},
        {8'd3, 48'hA1_B2_C3_00_00_00},
        {8'd0, 48'hEE_EE_EE_EE_EE_EE},
        {8'd6, 48'h00_FF_5A_A5_0F_F0},
        {8'd1, 48'h7E_00_00_00_00_00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        sda_drv = 1'b1;
    logic        sda_oe;
    logic [47:0] cfg_o;
    logic        sda_bus;
    int          checks = 0;
    int          failures = 0;
    int          oe_viol = 0;
    logic [7:0]  model [6];
    logic        done = 1'b0;

    assign sda_bus = sda_drv & ~sda_oe;

    always #10 clk = ~clk;

    clkcfg_i2c_target i_clkcfg_i2c_target (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe),
        .cfg_o  (cfg_o)
    );

    // R10 monitor: SDA drive must not change while the bench holds SCL high
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    always @(negedge clk) begin
        if (rst_n && scl && scl_prev && sda_oe != oe_prev) oe_viol++;
        oe_prev  = sda_oe;
        scl_prev = scl;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(posedge clk);
        #1;
    endtask

    task automatic clk_bit(input logic b, output logic seen);
        sda_drv = b; qwait();
        scl = 1'b1; qwait();
        seen = sda_bus; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; qwait();
        scl = 1'b1; qwait();
        sda_drv = 1'b0; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; qwait();
        scl = 1'b1; qwait();
        sda_drv = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        clk_bit(~give_ack, s);
    endtask

    function automatic logic [47:0] model_flat();
        logic [47:0] f;
        for (int k = 0; k < 6; k++) f[k*8 +: 8] = model[k];
        return f;
    endfunction

    task automatic readback(input string tag);
        logic       a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hD3, a);
        chk({"R2 read address ack ", tag}, a, 1'b1);
        recv_byte(d, 1'b1);
        chk({"R7 byte count ", tag}, d, 8'd6);
        for (int k = 0; k < 6; k++) begin
            recv_byte(d, k != 5);
            chk({"R7 readback ", tag}, d, model[k]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic       a;
        logic       s;
        logic [7:0] d;
        int         n;
        model[0] = 8'h00;
        for (int k = 1; k < 6; k++) model[k] = 8'hFF;
        repeat (5) @(posedge clk);
        #1;
        // R1: reset values
        chk("R1 reset cfg", cfg_o, model_flat());
        chk("R1 reset sda_oe", sda_oe, 1'b0);
        rst_n = 1'b1;
        qwait();

        // table of block writes, each followed by a full readback
        for (int v = 0; v < NV; v++) begin
            n = int'(WR_TAB[v][55:48]);
            bus_start();
            send_byte(8'hD2, a);
            chk("R2 write address ack", a, 1'b1);
            send_byte(8'h3C, a);
            chk("R3 command byte ack", a, 1'b1);
            send_byte(8'h99, a);
            chk("R3 count byte ack", a, 1'b1);
            for (int j = 0; j < n; j++) begin
                send_byte(WR_TAB[v][47 - 8*j -: 8], a);
                chk("R4 data ack", a, 1'b1);
                model[j] = WR_TAB[v][47 - 8*j -: 8];
            end
            bus_stop();
            qwait();
            chk("R5 R4 R3 cfg after write", cfg_o, model_flat());
            readback("table");
        end

        // R2: foreign address is not acknowledged and a following byte changes nothing
        bus_start();
        send_byte(8'hA4, a);
        chk("R2 foreign address nack", a, 1'b0);
        send_byte(8'h00, a);
        chk("R2 byte after foreign address nack", a, 1'b0);
        bus_stop();
        qwait();
        chk("R2 cfg unchanged after foreign address", cfg_o, model_flat());

        // R6: bytes past register 5 are acked and ignored
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h01, a);
        send_byte(8'h02, a);
        for (int j = 0; j < 9; j++) begin
            send_byte(8'h10 + 8'(j), a);
            if (j < 6) model[j] = 8'h10 + 8'(j);
            else chk("R6 extra byte ack", a, 1'b1);
        end
        bus_stop();
        qwait();
        chk("R6 cfg after overlong write", cfg_o, model_flat());

        // R9: repeated START after a complete byte switches to a read
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h42, a);
        model[0] = 8'h42;
        readback("R9 restart after byte");

        // R9: repeated START in the middle of a data byte
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        for (int i = 0; i < 4; i++) clk_bit(1'b0, s);
        bus_start();
        send_byte(8'hD3, a);
        chk("R9 address after mid-byte restart", a, 1'b1);
        recv_byte(d, 1'b0);
        chk("R9 count after mid-byte restart", d, 8'd6);
        bus_stop();
        qwait();
        chk("R9 cfg unchanged by cut byte", cfg_o, model_flat());

        // R8: NACK after the count byte releases SDA
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(d, 1'b0);
        chk("R8 count before nack", d, 8'd6);
        chk("R8 sda_oe released after nack", sda_oe, 1'b0);
        d = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            d[i] = s;
        end
        chk("R8 bus stays high after nack", d, 8'hFF);
        bus_stop();

        chk("R10 oe changes while SCL high", oe_viol, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule